// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs the sixteen register data-processing operations of a 32-bit RISC core. The core passes in the control fields of the instruction, the first operand taken from the register file, a second operand that an external shifter has already formed, that shifter's carry-out, and the current N, Z, C and V flags. In return the block gives the result, a destination write enable and index, the next flag values, and a request to restore the status register from its saved copy.

The block has one registered stage with a valid/ready stream on each side. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or being drained in the same cycle (`out_ready` high). The output stage therefore absorbs back-pressure for one operation. While `out_valid` is high and `out_ready` is low, every output holds its value and no new request is accepted.

The flags are packed as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. `result` always carries the computed value, including for compare-type operations, which do not write it.

Top module: `dp_alu`

## Requirements
- R1: `opcode` (instruction bits 24:21) selects the operation as follows: 0 AND, 1 EOR, 2 SUB (a-b), 3 RSB (b-a), 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST (a&b), 9 TEQ (a^b), 10 CMP (a-b), 11 CMN (a+b), 12 ORR, 13 MOV (b), 14 BIC (a&~b), 15 MVN (~b). The value of that operation appears on `result`.
- R2: `s_flag` is instruction bit 20. `dest_idx` is instruction bits 15:12 and is presented unchanged on `wr_idx`.
- R3: With `s_flag` set, a logical operation (AND, EOR, TST, TEQ, ORR, MOV, BIC, MVN) sets C to `shift_c` and leaves V equal to the incoming V.
- R4: With `s_flag` set, an arithmetic operation sets C to the carry out of bit 31 and sets V on signed overflow. For subtract-type operations, C=1 means that no borrow occurred.
- R5: ADC adds the incoming C. SBC and RSC subtract one more when the incoming C is 0.
- R6: TST, TEQ, CMP and CMN drive `wr_en` low. Every other opcode drives `wr_en` high.
- R7: With `s_flag` set, Z is 1 exactly when `result` is zero and N equals `result` bit 31. With `s_flag` clear, all four output flags equal the incoming flags.
- R8: `sr_restore` is high exactly when `s_flag` is set and `dest_idx` is 15. This output requests both the status restore and a pipeline flush.
- R9: A request is accepted when `in_valid` and `in_ready` are high on a rising edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs stay stable.
- R10: A synchronous `rst` clears `out_valid` on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| opcode | input | 4 | Operation select (instruction bits 24:21) |
| s_flag | input | 1 | Flag-update enable (instruction bit 20) |
| dest_idx | input | 4 | Destination register index (instruction bits 15:12) |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand from the shifter |
| shift_c | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current N,Z,C,V |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | DATA_W | Operation value |
| wr_en | output | 1 | Write the destination register |
| wr_idx | output | 4 | Destination register index |
| flags_out | output | 4 | Next N,Z,C,V |
| sr_restore | output | 1 | Restore status from its saved copy and flush the pipeline |

## Verification
The bench builds the block with the default `DATA_W` of 32. At that width the signed boundaries 0x7FFFFFFF and 0x80000000 and the all-ones and zero words are exactly the values where carry and overflow change, so they can be reached directly. Every opcode is swept across those corner operands with random incoming flags and compared against an arithmetic model based on wide integers. Random operands follow the sweep. Hand-computed table entries and directed tests then cover the carry-in forms, a write to register 15, reset, and a stall followed by a drain.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  localparam int OP_W  = 4;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

  typedef enum logic [OP_W-1:0] {
    OP_AND, OP_EOR, OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
    OP_TST, OP_TEQ, OP_CMP, OP_CMN, OP_ORR, OP_MOV, OP_BIC, OP_MVN
  } alu_op_e;

  typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } cin_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            is_arith,
  output logic            is_compare,
  output logic            swap_ops,
  output logic            invert_y,
  output cin_mode_e       cin_mode
);
  always_comb begin
    is_arith   = 1'b0;
    swap_ops   = 1'b0;
    invert_y   = 1'b0;
    cin_mode   = CIN_ZERO;
    is_compare = (opcode[3:2] == 2'b10);
    unique case (alu_op_e'(opcode))
      OP_ADD, OP_CMN: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; cin_mode = CIN_FLAG; end
      OP_SUB, OP_CMP: begin is_arith = 1'b1; invert_y = 1'b1; cin_mode = CIN_ONE; end
      OP_SBC: begin is_arith = 1'b1; invert_y = 1'b1; cin_mode = CIN_FLAG; end
      OP_RSB: begin is_arith = 1'b1; invert_y = 1'b1; swap_ops = 1'b1; cin_mode = CIN_ONE; end
      OP_RSC: begin is_arith = 1'b1; invert_y = 1'b1; swap_ops = 1'b1; cin_mode = CIN_FLAG; end
      default: ;
    endcase
  end
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              swap_ops,
  input  logic              invert_y,
  input  cin_mode_e         cin_mode,
  input  logic              c_in_flag,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W-1:0] x, y_raw, y;
  logic              cin;

  always_comb begin
    x     = swap_ops ? b : a;
    y_raw = swap_ops ? a : b;
    y     = invert_y ? ~y_raw : y_raw;
    unique case (cin_mode)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = c_in_flag;
      default:  cin = 1'b0;
    endcase
    {c_out, sum} = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end
endmodule

// File: rtl/dp_logic.sv
module dp_logic
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (alu_op_e'(opcode))
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        opcode,
  input  logic              s_flag,
  input  logic [3:0]        dest_idx,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              shift_c,
  input  logic [3:0]        flags_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [3:0]        wr_idx,
  output logic [3:0]        flags_out,
  output logic              sr_restore
);
  localparam int MSB = DATA_W - 1;

  logic              is_arith, is_compare, swap_ops, invert_y;
  cin_mode_e         cin_mode;
  logic [DATA_W-1:0] sum, lres, res_d;
  logic              c_out, ovf;
  flags_t            f_in, f_d;
  logic              in_fire;

  assign f_in    = flags_t'(flags_in);
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  dp_decode u_dec (
    .opcode(opcode), .is_arith(is_arith), .is_compare(is_compare),
    .swap_ops(swap_ops), .invert_y(invert_y), .cin_mode(cin_mode)
  );

  dp_addsub #(.DATA_W(DATA_W)) u_add (
    .a(op_a), .b(op_b), .swap_ops(swap_ops), .invert_y(invert_y),
    .cin_mode(cin_mode), .c_in_flag(f_in.c), .sum(sum), .c_out(c_out), .ovf(ovf)
  );

  dp_logic #(.DATA_W(DATA_W)) u_log (
    .opcode(opcode), .a(op_a), .b(op_b), .res(lres)
  );

  always_comb begin
    res_d = is_arith ? sum : lres;
    f_d   = f_in;
    if (s_flag) begin
      f_d.n = res_d[MSB];
      f_d.z = (res_d == '0);
      f_d.c = is_arith ? c_out : shift_c;
      f_d.v = is_arith ? ovf : f_in.v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
    if (in_fire) begin
      result     <= res_d;
      wr_en      <= !is_compare;
      wr_idx     <= dest_idx;
      flags_out  <= f_d;
      sr_restore <= s_flag && (dest_idx == PC_IDX);
    end
  end

  // R10: reset empties the output stage
  assert_reset_clears_R10: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: stalled output holds its contents
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flags_out)
                                   && $stable(wr_en) && $stable(sr_restore)));

  // R7: flags pass through when flag update is off
  assert_flags_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (in_fire && !s_flag) |=> (flags_out == $past(flags_in)));

  // R7: zero flag tracks the registered result
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (in_fire && s_flag) |=> (flags_out[2] == (result == '0)) && (flags_out[3] == result[MSB]));

  // R3: logical ops take carry from the shifter and keep V
  assert_logic_cv_R3: assert property (@(posedge clk) disable iff (rst)
    (in_fire && s_flag && !is_arith) |=>
      (flags_out[1] == $past(shift_c)) && (flags_out[0] == $past(flags_in[0])));

  // R6: compare-type opcodes never write the destination
  assert_compare_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    (in_fire && opcode[3:2] == 2'b10) |=> !wr_en);

  // R8: restore request only with flag update and destination 15
  assert_restore_R8: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> (sr_restore == ($past(s_flag) && $past(dest_idx) == 4'd15)));
endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  localparam int W = 32;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [3:0] opcode = '0, dest_idx = '0, flags_in = '0;
  logic s_flag = 1'b0, shift_c = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] result;
  logic wr_en, sr_restore;
  logic [3:0] wr_idx, flags_out;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dp_alu #(.DATA_W(W)) u_dp_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .s_flag(s_flag), .dest_idx(dest_idx),
    .op_a(op_a), .op_b(op_b), .shift_c(shift_c), .flags_in(flags_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .wr_en(wr_en), .wr_idx(wr_idx), .flags_out(flags_out), .sr_restore(sr_restore)
  );

  // {op, s, rd, a, b, shc, flags_in, exp_result, exp_wr, exp_flags, exp_restore}
  localparam logic [115:0] VEC [NV] = '{
    {4'd0, 1'b1,4'd1, 32'hF0F0F0F0,32'h0FF00FF0,1'b1,4'b0001, 32'h00F000F0,1'b1,4'b0011,1'b0},
    {4'd1, 1'b1,4'd2, 32'hFFFFFFFF,32'hFFFFFFFF,1'b0,4'b0000, 32'h00000000,1'b1,4'b0100,1'b0},
    {4'd2, 1'b1,4'd1, 32'h00000005,32'h00000003,1'b0,4'b0000, 32'h00000002,1'b1,4'b0010,1'b0},
    {4'd2, 1'b1,4'd1, 32'h00000003,32'h00000005,1'b0,4'b0000, 32'hFFFFFFFE,1'b1,4'b1000,1'b0},
    {4'd3, 1'b1,4'd1, 32'h00000001,32'h0000000A,1'b0,4'b0000, 32'h00000009,1'b1,4'b0010,1'b0},
    {4'd4, 1'b1,4'd1, 32'h7FFFFFFF,32'h00000001,1'b0,4'b0000, 32'h80000000,1'b1,4'b1001,1'b0},
    {4'd4, 1'b1,4'd1, 32'hFFFFFFFF,32'h00000001,1'b0,4'b0000, 32'h00000000,1'b1,4'b0110,1'b0},
    {4'd5, 1'b1,4'd1, 32'h00000001,32'h00000001,1'b0,4'b0010, 32'h00000003,1'b1,4'b0000,1'b0},
    {4'd6, 1'b1,4'd1, 32'h00000005,32'h00000003,1'b0,4'b0000, 32'h00000001,1'b1,4'b0010,1'b0},
    {4'd7, 1'b1,4'd1, 32'h00000003,32'h00000005,1'b0,4'b0000, 32'h00000001,1'b1,4'b0010,1'b0},
    {4'd8, 1'b1,4'd0, 32'h000000F0,32'h0000000F,1'b0,4'b0001, 32'h00000000,1'b0,4'b0101,1'b0},
    {4'd9, 1'b1,4'd0, 32'h000000AA,32'h000000AA,1'b1,4'b0000, 32'h00000000,1'b0,4'b0110,1'b0},
    {4'd10,1'b1,4'd0, 32'h80000000,32'h00000001,1'b0,4'b0000, 32'h7FFFFFFF,1'b0,4'b0011,1'b0},
    {4'd11,1'b1,4'd0, 32'h80000000,32'h80000000,1'b0,4'b0000, 32'h00000000,1'b0,4'b0111,1'b0},
    {4'd12,1'b1,4'd1, 32'h00000000,32'h00000000,1'b1,4'b1000, 32'h00000000,1'b1,4'b0110,1'b0},
    {4'd13,1'b1,4'd1, 32'h00000000,32'h80000000,1'b0,4'b0011, 32'h80000000,1'b1,4'b1001,1'b0},
    {4'd14,1'b0,4'd1, 32'h000000FF,32'h0000000F,1'b1,4'b1010, 32'h000000F0,1'b1,4'b1010,1'b0},
    {4'd15,1'b1,4'd15,32'h00000000,32'h00000000,1'b1,4'b0000, 32'hFFFFFFFF,1'b1,4'b1010,1'b1},
    {4'd2, 1'b0,4'd15,32'h00000010,32'h00000001,1'b0,4'b0101, 32'h0000000F,1'b1,4'b0101,1'b0}
  };

  // Reference: returns {result, wr, flags, restore}
  function automatic logic [37:0] model(input logic [3:0] op, input logic s, input logic [3:0] rd,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic shc, input logic [3:0] fl);
    longint ua, ub, sa, sb, us, ss;
    logic [31:0] r;
    logic arith, c, v, cin;
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cin = fl[1];
    arith = 1'b1; us = 0; ss = 0; r = '0;
    case (op)
      4'd2, 4'd10: begin us = ua - ub; ss = sa - sb; end
      4'd3:        begin us = ub - ua; ss = sb - sa; end
      4'd4, 4'd11: begin us = ua + ub; ss = sa + sb; end
      4'd5:        begin us = ua + ub + longint'(cin); ss = sa + sb + longint'(cin); end
      4'd6:        begin us = ua - ub - longint'(!cin); ss = sa - sb - longint'(!cin); end
      4'd7:        begin us = ub - ua - longint'(!cin); ss = sb - sa - longint'(!cin); end
      default: arith = 1'b0;
    endcase
    case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      default:     r = us[31:0];
    endcase
    if (arith) begin
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) c = (us > 64'sh0FFFFFFFF);
      else c = (us >= 0);
      v = (ss > 64'sh7FFFFFFF) || (ss < -64'sh80000000);
    end else begin
      c = shc; v = fl[0];
    end
    return {r, !(op >= 4'd8 && op <= 4'd11),
            s ? {r[31], (r == 32'd0), c, v} : fl,
            (s && rd == 4'd15)};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic s, input logic [3:0] rd);
    if (s && rd == 4'd15) return "R8";
    if (!s) return "R7";
    if (op >= 4'd8 && op <= 4'd11) return "R6";
    if (op >= 4'd5 && op <= 4'd7) return "R5";
    if (op == 4'd2 || op == 4'd3 || op == 4'd4) return "R4";
    return "R3";
  endfunction

  task automatic drive(input logic [3:0] op, input logic s, input logic [3:0] rd,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic shc, input logic [3:0] fl);
    opcode = op; s_flag = s; dest_idx = rd; op_a = a; op_b = b;
    shift_c = shc; flags_in = fl;
  endtask

  task automatic compare(input string tag, input logic [37:0] exp);
    n_vec++;
    if (!out_valid || {result, wr_en, flags_out, sr_restore} !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%0b res=%h wr=%0b fl=%b rst=%0b exp res=%h wr=%0b fl=%b rst=%0b",
               tag, out_valid, result, wr_en, flags_out, sr_restore,
               exp[37:6], exp[5], exp[4:1], exp[0]);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  // one request through, sampled at the falling edge after acceptance
  task automatic apply(input logic [3:0] op, input logic s, input logic [3:0] rd,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic shc, input logic [3:0] fl, input string tag,
                       input logic [37:0] exp);
    @(negedge clk);
    drive(op, s, rd, a, b, shc, fl);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag, exp);
    n_vec++;
    if (wr_idx !== rd) begin
      n_bad++;
      $display("FAIL R2: wr_idx got %0d exp %0d", wr_idx, rd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [4];
    logic [37:0] first_exp;
    corner[0] = 32'h0; corner[1] = 32'h7FFFFFFF; corner[2] = 32'h80000000; corner[3] = 32'hFFFFFFFF;

    repeat (3) @(negedge clk);
    check_bit("R10 reset out_valid", out_valid, 1'b0);
    check_bit("R9 ready when empty", in_ready, 1'b1);
    rst = 1'b0;

    // hand-computed table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][115:112], VEC[i][111], VEC[i][110:107], VEC[i][106:75], VEC[i][74:43],
            VEC[i][42], VEC[i][41:38], tag_of(VEC[i][115:112], VEC[i][111], VEC[i][110:107]),
            VEC[i][37:0]);
    end

    // every opcode across corner operands (R1, R4, R3)
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          logic [3:0] fl;
          logic shc;
          fl = 4'($urandom); shc = 1'($urandom);
          apply(4'(op), 1'b1, 4'd3, corner[i], corner[j], shc, fl, "R1 corner",
                model(4'(op), 1'b1, 4'd3, corner[i], corner[j], shc, fl));
        end
      end
    end

    // random operands, both S values
    for (int k = 0; k < 600; k++) begin
      logic [3:0] op, rd, fl;
      logic s, shc;
      logic [31:0] a, b;
      op = 4'($urandom); rd = 4'($urandom); fl = 4'($urandom);
      s = 1'($urandom); shc = 1'($urandom); a = $urandom; b = $urandom;
      apply(op, s, rd, a, b, shc, fl, tag_of(op, s, rd), model(op, s, rd, a, b, shc, fl));
    end

    // R9: stall then drain
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'd4, 1'b1, 4'd5, 32'd100, 32'd23, 1'b0, 4'b0000);
    in_valid = 1'b1;
    first_exp = model(4'd4, 1'b1, 4'd5, 32'd100, 32'd23, 1'b0, 4'b0000);
    @(negedge clk);
    compare("R9 first accepted", first_exp);
    check_bit("R9 not ready while stalled", in_ready, 1'b0);
    drive(4'd2, 1'b1, 4'd6, 32'd1, 32'd2, 1'b0, 4'b1111);
    repeat (2) @(negedge clk);
    compare("R9 held under stall", first_exp);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R9 second after drain", model(4'd2, 1'b1, 4'd6, 32'd1, 32'd2, 1'b0, 4'b1111));
    @(negedge clk);
    check_bit("R9 empties when drained", out_valid, 1'b0);

    // R10: reset while a result is present
    drive(4'd13, 1'b0, 4'd1, 32'd0, 32'd7, 1'b0, 4'b0000);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10 valid before reset", out_valid, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_bit("R10 reset clears valid", out_valid, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule